// File: doc/BRIEF.md
# Weighted Min-Max Variable Node Processor for GF(4)

This block does the variable-node update of a non-binary LDPC decoder over GF(4). It uses the min-max algorithm. Each message is a vector of four unsigned reliability distances, one for each field element. A smaller distance means a more likely symbol. For every variable, the caller supplies the following, all in one clock:

- the quantised channel vector of that variable;
- the incoming check-to-variable messages, one for each of the `DEG` connected edges;
- the variable-to-check messages that the block produced for the same edges in the previous iteration.

For each edge, the block forms the extrinsic sum: the channel vector plus every incoming message except the one arriving on that edge. It then subtracts the smallest of the four entries, so the most likely symbol sits at distance zero. The result is clipped to the value range. This fresh vector is blended with the previous iteration's message using a fixed weight alpha = `ALPHA_NUM / 2^ALPHA_SHIFT`, which is 3/4 by default. The block also gives a tentative hard decision taken from the full sum.

One variable is accepted on every clock in which `in_valid` is high. The results appear one cycle later. Permutation, message storage and iteration control are left to the surrounding decoder.

Top module: `vnu_wmm_top`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was sampled high. The results for that input appear on the outputs in the same cycle.
- R2: When `in_valid` is sampled low, `v2c_msg`, `hard_sym` and the vector contents are unchanged in the next cycle, whatever the other inputs do.
- R3: While reset is asserted and after its release, before any valid input, `out_valid`, `v2c_msg` and `hard_sym` are all zero.
- R4: For edge e and symbol a, the fresh value is `intr[a] + sum of chk[j][a]` over all edges j != e, computed without overflow.
- R5: The fresh vector of each edge is normalised by subtracting its own minimum entry. When `first_iter` is high, the output equals the normalised vector, which therefore contains a zero.
- R6: A normalised entry above 2^W-1 (1023 by default) is clipped to 2^W-1.
- R7: When `first_iter` is low, each output entry is `floor((ALPHA_NUM*new + (2^ALPHA_SHIFT-ALPHA_NUM)*old) / 2^ALPHA_SHIFT)`, which is `floor((3*new + old)/4)` by default. Here `old` is the matching entry of `prev_msg`. If `prev_msg` is all zero for an edge, that edge's output keeps a zero entry.
- R8: `hard_sym` is the index of the smallest entry of `intr + sum of all chk`. On a tie, the lowest index wins.
- R9: In a packed vector, symbol a of edge e occupies bits `[(e*4+a)*W +: W]`, and `intr_llr` entry a occupies bits `[a*W +: W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A variable is presented this cycle |
| first_iter | input | 1 | First iteration: skip blending |
| intr_llr | input | 4*W | Channel reliability vector |
| chk_msg | input | DEG*4*W | Incoming check-to-variable messages |
| prev_msg | input | DEG*4*W | Previous-iteration outgoing messages |
| out_valid | output | 1 | Results valid |
| v2c_msg | output | DEG*4*W | Outgoing variable-to-check messages |
| hard_sym | output | 2 | Tentative symbol decision |

## Verification
Clipping and blending can fall in the same cycle. The bench provokes this by driving channel and check values near full scale with `first_iter` low, so a clipped 1023 entry enters the 3/4 weighting. The bench judges the output against its own integer model of clip-then-blend.

Normalisation and the hard decision can also coincide on tied entries. Equal totals on several symbols must yield the lowest index, while each edge still shows a zero.

// File: rtl/vnu_pkg.sv
package vnu_pkg;
   localparam int GF_Q  = 4;
   localparam int SYM_W = 2;
   typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/vnu_argmin4.sv
module vnu_argmin4 #(
   parameter int VW = 12
) (
   input  logic [vnu_pkg::GF_Q-1:0][VW-1:0] v,
   output vnu_pkg::sym_t                    idx
);
   import vnu_pkg::*;
   sym_t lo_i, hi_i;

   always_comb begin
      lo_i = (v[1] < v[0]) ? sym_t'(1) : sym_t'(0);
      hi_i = (v[3] < v[2]) ? sym_t'(3) : sym_t'(2);
      idx  = (v[hi_i] < v[lo_i]) ? hi_i : lo_i;
   end
endmodule

// File: rtl/vnu_cmul.sv
module vnu_cmul #(
   parameter int IW    = 10,
   parameter int KBITS = 2,
   parameter int K     = 3,
   localparam int OW   = IW + KBITS
) (
   input  logic [IW-1:0] v,
   output logic [OW-1:0] p
);
   logic [OW-1:0] acc [0:KBITS];
   assign acc[0] = '0;

   for (genvar i = 0; i < KBITS; i++) begin : g_bit
      if (((K >> i) & 1) == 1) begin : g_add
         assign acc[i+1] = acc[i] + (OW'(v) << i);
      end else begin : g_skip
         assign acc[i+1] = acc[i];
      end
   end

   assign p = acc[KBITS];
endmodule

// File: rtl/vnu_edge.sv
module vnu_edge #(
   parameter int W           = 10,
   parameter int SW          = 12,
   parameter int ALPHA_NUM   = 3,
   parameter int ALPHA_SHIFT = 2
) (
   input  logic [vnu_pkg::GF_Q-1:0][SW-1:0] ext,
   input  logic [vnu_pkg::GF_Q-1:0][W-1:0]  prev,
   input  logic                             first,
   output logic [vnu_pkg::GF_Q-1:0][W-1:0]  res
);
   import vnu_pkg::*;
   localparam int MAXV  = (1 << W) - 1;
   localparam int OLD_K = (1 << ALPHA_SHIFT) - ALPHA_NUM;
   localparam int PW    = W + ALPHA_SHIFT;

   sym_t                   mn_i;
   logic [SW-1:0]          mn;
   logic [GF_Q-1:0][W-1:0] nv;

   vnu_argmin4 #(.VW(SW)) u_min (.v(ext), .idx(mn_i));
   assign mn = ext[mn_i];

   always_comb begin
      for (int a = 0; a < GF_Q; a++) begin
         logic [SW-1:0] d;
         d     = ext[a] - mn;
         nv[a] = (d > SW'(MAXV)) ? W'(MAXV) : W'(d);
      end
   end

   if (OLD_K == 0) begin : g_replace
      assign res = nv;
   end else begin : g_blend
      for (genvar a = 0; a < GF_Q; a++) begin : g_sym
         logic [PW-1:0] pn, po, bl;
         vnu_cmul #(.IW(W), .KBITS(ALPHA_SHIFT), .K(ALPHA_NUM)) u_new (.v(nv[a]),   .p(pn));
         vnu_cmul #(.IW(W), .KBITS(ALPHA_SHIFT), .K(OLD_K))     u_old (.v(prev[a]), .p(po));
         assign bl     = pn + po;
         assign res[a] = first ? nv[a] : W'(bl >> ALPHA_SHIFT);
      end
   end
endmodule

// File: rtl/vnu_wmm_top.sv
module vnu_wmm_top #(
   parameter int DEG         = 3,
   parameter int W           = 10,
   parameter int ALPHA_NUM   = 3,
   parameter int ALPHA_SHIFT = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic                         first_iter,
   input  logic [vnu_pkg::GF_Q*W-1:0]     intr_llr,
   input  logic [DEG*vnu_pkg::GF_Q*W-1:0] chk_msg,
   input  logic [DEG*vnu_pkg::GF_Q*W-1:0] prev_msg,
   output logic                         out_valid,
   output logic [DEG*vnu_pkg::GF_Q*W-1:0] v2c_msg,
   output logic [vnu_pkg::SYM_W-1:0]     hard_sym
);
   import vnu_pkg::*;
   localparam int SW = W + $clog2(DEG + 1);
   localparam int VW = DEG * GF_Q * W;

   if (DEG < 2)         begin : g_chk_deg   $error("DEG must be at least 2");       end
   if (W < 2)           begin : g_chk_w     $error("W must be at least 2");         end
   if (ALPHA_SHIFT < 1) begin : g_chk_shift $error("ALPHA_SHIFT must be positive"); end
   if (ALPHA_NUM < 1 || ALPHA_NUM > (1 << ALPHA_SHIFT)) begin : g_chk_alpha
      $error("ALPHA_NUM out of range");
   end

   logic [GF_Q-1:0][W-1:0]            intr_v;
   logic [DEG-1:0][GF_Q-1:0][W-1:0]   chk_v, prev_v, res_v;
   logic [GF_Q-1:0][SW-1:0]           total;
   logic [DEG-1:0][GF_Q-1:0][SW-1:0]  ext_v;
   logic [VW-1:0]                     res_flat;
   sym_t                              hd;

   always_comb begin
      for (int a = 0; a < GF_Q; a++) begin
         intr_v[a] = intr_llr[a*W +: W];
         total[a]  = SW'(intr_v[a]);
      end
      for (int e = 0; e < DEG; e++) begin
         for (int a = 0; a < GF_Q; a++) begin
            chk_v[e][a]  = chk_msg[(e*GF_Q+a)*W +: W];
            prev_v[e][a] = prev_msg[(e*GF_Q+a)*W +: W];
            total[a]     = total[a] + SW'(chk_v[e][a]);
         end
      end
      for (int e = 0; e < DEG; e++) begin
         for (int a = 0; a < GF_Q; a++) begin
            ext_v[e][a] = total[a] - SW'(chk_v[e][a]);
         end
      end
   end

   for (genvar e = 0; e < DEG; e++) begin : g_edge
      vnu_edge #(
         .W(W), .SW(SW), .ALPHA_NUM(ALPHA_NUM), .ALPHA_SHIFT(ALPHA_SHIFT)
      ) u_edge (
         .ext(ext_v[e]), .prev(prev_v[e]), .first(first_iter), .res(res_v[e])
      );
      for (genvar a = 0; a < GF_Q; a++) begin : g_pack
         assign res_flat[(e*GF_Q+a)*W +: W] = res_v[e][a];
      end
   end

   vnu_argmin4 #(.VW(SW)) u_hd (.v(total), .idx(hd));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         v2c_msg   <= '0;
         hard_sym  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            v2c_msg  <= res_flat;
            hard_sym <= hd;
         end
      end
   end
endmodule

// File: rtl/vnu_wmm_chk.sv
module vnu_wmm_chk #(
   parameter int DEG = 3,
   parameter int W   = 10
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 first_iter,
   input logic [DEG*4*W-1:0]   prev_msg,
   input logic                 out_valid,
   input logic [DEG*4*W-1:0]   v2c_msg,
   input logic [1:0]           hard_sym
);
   logic [DEG-1:0] out_has_zero, prev_all_zero;

   always_comb begin
      for (int e = 0; e < DEG; e++) begin
         out_has_zero[e]  = 1'b0;
         prev_all_zero[e] = 1'b1;
         for (int a = 0; a < 4; a++) begin
            if (v2c_msg[(e*4+a)*W +: W] == '0)  out_has_zero[e]  = 1'b1;
            if (prev_msg[(e*4+a)*W +: W] != '0) prev_all_zero[e] = 1'b0;
         end
      end
   end

   // R1
   a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));

   // R2
   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(v2c_msg) && $stable(hard_sym)));

   for (genvar e = 0; e < DEG; e++) begin : g_edge_chk
      // R5
      a_r5_first_has_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && first_iter) |=> out_has_zero[e]);
      // R7
      a_r7_zero_prev_keeps_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !first_iter && prev_all_zero[e]) |=> out_has_zero[e]);
   end
endmodule

bind vnu_wmm_top vnu_wmm_chk #(.DEG(DEG), .W(W)) u_vnu_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_iter(first_iter),
   .prev_msg(prev_msg), .out_valid(out_valid), .v2c_msg(v2c_msg),
   .hard_sym(hard_sym)
);

// File: tb/tb_vnu_wmm_top.sv
module tb_vnu_wmm_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEG = 3;
   localparam int W   = 10;
   localparam int MAXV = (1 << W) - 1;
   localparam int VW  = DEG * 4 * W;

   logic clk = 0, rst_n = 0, in_valid = 0, first_iter = 0;
   logic [4*W-1:0] intr_llr = '0;
   logic [VW-1:0]  chk_msg = '0, prev_msg = '0;
   logic           out_valid;
   logic [VW-1:0]  v2c_msg;
   logic [1:0]     hard_sym;

   vnu_wmm_top dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_iter(first_iter),
      .intr_llr(intr_llr), .chk_msg(chk_msg), .prev_msg(prev_msg),
      .out_valid(out_valid), .v2c_msg(v2c_msg), .hard_sym(hard_sym)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   int ti[4];
   int tc[DEG][4];
   int tp[DEG][4];
   logic           e_valid = 0;
   logic [VW-1:0]  e_msg = '0;
   logic [1:0]     e_hd = '0;

   task automatic pack_inputs();
      for (int a = 0; a < 4; a++) intr_llr[a*W +: W] = W'(ti[a]);
      for (int e = 0; e < DEG; e++)
         for (int a = 0; a < 4; a++) begin
            chk_msg[(e*4+a)*W +: W]  = W'(tc[e][a]);
            prev_msg[(e*4+a)*W +: W] = W'(tp[e][a]);
         end
   endtask

   // Reference model: R4 sum, R5 normalisation, R6 clip, R7 blend, R8 decision, R9 packing
   task automatic model(input bit first);
      int tot[4];
      int best;
      for (int a = 0; a < 4; a++) begin
         tot[a] = ti[a];
         for (int e = 0; e < DEG; e++) tot[a] += tc[e][a];
      end
      best = 0;
      for (int a = 1; a < 4; a++) if (tot[a] < tot[best]) best = a;
      e_hd = 2'(best);
      for (int e = 0; e < DEG; e++) begin
         int x[4];
         int mn;
         for (int a = 0; a < 4; a++) x[a] = tot[a] - tc[e][a];
         mn = x[0];
         for (int a = 1; a < 4; a++) if (x[a] < mn) mn = x[a];
         for (int a = 0; a < 4; a++) begin
            int nv, r;
            nv = x[a] - mn;
            if (nv > MAXV) nv = MAXV;
            r = first ? nv : (3*nv + tp[e][a]) / 4;
            e_msg[(e*4+a)*W +: W] = W'(r);
         end
      end
   endtask

   task automatic compare(input string tag);
      n_cmp++;
      if (out_valid !== e_valid) begin
         n_bad++;
         $display("FAIL R1 (%s): out_valid actual %0b expected %0b", tag, out_valid, e_valid);
      end
      n_cmp++;
      if (hard_sym !== e_hd) begin
         n_bad++;
         $display("FAIL R8 (%s): hard_sym actual %0d expected %0d", tag, hard_sym, e_hd);
      end
      n_cmp++;
      if (v2c_msg !== e_msg) begin
         n_bad++;
         $display("FAIL %s: v2c_msg actual %h expected %h", tag, v2c_msg, e_msg);
      end
   endtask

   // one clock: drive at negedge, check at the following negedge
   task automatic step(input bit v, input bit first, input string tag);
      in_valid = v;
      first_iter = first;
      pack_inputs();
      if (v) model(first);
      e_valid = v;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic fill_rand(input int hi);
      for (int a = 0; a < 4; a++) ti[a] = $urandom_range(0, hi);
      for (int e = 0; e < DEG; e++)
         for (int a = 0; a < 4; a++) begin
            tc[e][a] = $urandom_range(0, hi);
            tp[e][a] = $urandom_range(0, MAXV);
         end
   endtask

   task automatic fill_const(input int vi, input int vc, input int vp);
      for (int a = 0; a < 4; a++) ti[a] = vi;
      for (int e = 0; e < DEG; e++)
         for (int a = 0; a < 4; a++) begin
            tc[e][a] = vc;
            tp[e][a] = vp;
         end
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      compare("R3 during reset");
      rst_n = 1;
      @(negedge clk);
      compare("R3 after reset");

      // R4/R5/R9: distinct per-edge values, first iteration
      ti = '{5, 1, 9, 3};
      tc[0] = '{0, 7, 2, 4}; tc[1] = '{6, 0, 1, 8}; tc[2] = '{3, 3, 0, 11};
      fill_prev_zero();
      step(1, 1, "R4 R5 R9 first iteration");

      // R2: inputs change while idle
      fill_rand(MAXV);
      step(0, 0, "R2 idle hold");
      step(0, 1, "R2 idle hold");

      // R7: blend with stored message
      ti = '{5, 1, 9, 3};
      tc[0] = '{0, 7, 2, 4}; tc[1] = '{6, 0, 1, 8}; tc[2] = '{3, 3, 0, 11};
      for (int e = 0; e < DEG; e++) tp[e] = '{100, 0, 37, 1023};
      step(1, 0, "R7 blend");

      // R8 ties: all equal -> 0; tie between 2 and 3 -> 2
      fill_const(4, 4, 0);
      step(1, 1, "R8 full tie");
      fill_const(9, 9, 0);
      ti[2] = 1; ti[3] = 1;
      step(1, 1, "R8 tie 2/3");

      // R6: clip, first iteration and combined with blend
      fill_const(MAXV, MAXV, 200);
      for (int e = 0; e < DEG; e++) tc[e][1] = 0;
      ti[1] = 0;
      step(1, 1, "R6 clip first");
      step(1, 0, "R6 R7 clip and blend");

      // back-to-back traffic with random idles
      for (int k = 0; k < 300; k++) begin
         fill_rand((k % 3 == 0) ? MAXV : 63);
         step(($urandom_range(0, 3) != 0), $urandom_range(0, 1), "R4 R5 R7 random");
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   task automatic fill_prev_zero();
      for (int e = 0; e < DEG; e++) tp[e] = '{0, 0, 0, 0};
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule